// File: doc/BRIEF.md
# Dual-Mode DDS Programming Loader

This block collects the settings for a numerically controlled oscillator. A 40-bit staging register holds three settings: a 32-bit frequency tuning word, a 5-bit phase offset and a power-down flag. The remaining two bits are reserved. Software-side logic fills the staging register through one of two paths, selected by a mode input. In parallel mode the loader takes five byte writes on an 8-bit bus. In serial mode it takes forty single-bit shifts, using only the top data bit.

A write strobe moves data into the staging register. A separate commit strobe copies the staged word into the active register. The active register drives the oscillator through the output ports, so new settings take effect all at once. Both strobes are plain inputs, already synchronous to the core clock. The loader acts on the first clock at which a strobe is seen high after having been seen low.

Top module: `dds_prog_loader`

## Requirements
- R1: While reset is asserted, the frequency word, phase word and power-down outputs read zero, and the byte pointer returns to the first byte.
- R2: In parallel mode, the first byte of a frame carries the settings byte. Bits [7:3] are the phase word, bit 2 is power-down, and bits [1:0] are reserved.
- R3: In parallel mode, bytes two to five carry the frequency word, most significant byte first. Byte two is bits [31:24] and byte five is bits [7:0].
- R4: In parallel mode, each rising write-strobe edge stores the data byte at the slot the pointer selects and advances the pointer. Slots not written keep their earlier staged contents.
- R5: After five byte writes, further write-strobe edges are ignored until a commit edge or a reset.
- R6: A rising commit-strobe edge copies the staged word to the outputs and returns the pointer to the first byte. The outputs change at no other time.
- R7: In serial mode, each rising write-strobe edge shifts in data bit 7. The frame starts with frequency bit 0 and runs through frequency bit 31. It continues with the two reserved bits, then power-down, then phase bits 0 to 4. Serial shifts do not move the byte pointer.
- R8: If more than forty bits are shifted, only the last forty shifted bits are kept.
- R9: Nonzero reserved bits have no effect: they do not change the mode, the outputs or later parallel loads.
- R10: When a write edge and a commit edge arrive on the same clock, the commit is taken and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialMode | input | 1 | 1 selects serial shifting, 0 selects byte writes |
| wordStrobe | input | 1 | Write strobe, acted on at its rising edge |
| commitStrobe | input | 1 | Commit strobe, acted on at its rising edge |
| dataIn | input | 8 | Byte bus; bit 7 is the serial input |
| freqWord | output | 32 | Active frequency tuning word |
| phaseWord | output | 5 | Active phase offset |
| powerDown | output | 1 | Active power-down flag |

## Verification
The bench builds the loader with its default parameters: a 32-bit tuning word, a 5-bit phase word and an 8-bit bus. This makes a frame five bytes long in parallel mode and forty bits long in serial mode. Those sizes are small enough to test the full-pointer lock-out directly: extra writes are sent after the fifth byte, and a partial frame is committed over an older staged word. On the serial side, the bench checks the reversed bit order against the parallel layout and sends an overlong serial stream. It also checks that a write landing in the same clock as a commit is dropped.

// File: rtl/dds_loader_pkg.sv
package dds_loader_pkg;

  // Strobes passed from the control unit to the datapath
  typedef struct packed {
    logic writeByte;
    logic shiftBit;
    logic commit;
  } loadCtl_t;

endpackage

// File: rtl/dds_loader_ctrl.sv
module dds_loader_ctrl
  import dds_loader_pkg::*;
#(
  parameter int NUM_BYTES = 5,
  parameter int PTR_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serialMode,
  input  logic             wordStrobe,
  input  logic             commitStrobe,
  output loadCtl_t         ctl,
  output logic [PTR_W-1:0] bytePtr
);

  logic wordPrev, commitPrev;
  logic wordEdge, commitEdge, ptrFull;

  assign wordEdge   = wordStrobe & ~wordPrev;
  assign commitEdge = commitStrobe & ~commitPrev;
  assign ptrFull    = (bytePtr == PTR_W'(NUM_BYTES));

  // Commit has priority; a write landing on the same clock is dropped
  always_comb begin
    ctl.commit    = commitEdge;
    ctl.shiftBit  = wordEdge & serialMode & ~commitEdge;
    ctl.writeByte = wordEdge & ~serialMode & ~commitEdge & ~ptrFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordPrev   <= 1'b0;
      commitPrev <= 1'b0;
      bytePtr    <= '0;
    end else begin
      wordPrev   <= wordStrobe;
      commitPrev <= commitStrobe;
      if (ctl.commit)
        bytePtr <= '0;
      else if (ctl.writeByte)
        bytePtr <= bytePtr + PTR_W'(1);
    end
  end

endmodule

// File: rtl/dds_loader_path.sv
module dds_loader_path
  import dds_loader_pkg::*;
#(
  parameter int FREQ_W    = 32,
  parameter int PHASE_W   = 5,
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 5,
  parameter int PTR_W     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  loadCtl_t           ctl,
  input  logic [PTR_W-1:0]   bytePtr,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [FREQ_W-1:0]  freqWord,
  output logic [PHASE_W-1:0] phaseWord,
  output logic               powerDown
);

  localparam int WORD_W = FREQ_W + DATA_W;

  logic [WORD_W-1:0]    stageReg, stageNext, activeReg;
  logic [NUM_BYTES-1:0] byteHit;

  // One-hot slot select from the pointer
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_slot
    assign byteHit[k] = (bytePtr == PTR_W'(k));
  end

  always_comb begin
    stageNext = stageReg;
    if (ctl.shiftBit) begin
      // Right shift: the first bit sent ends in bit 0
      stageNext = {dataIn[DATA_W-1], stageReg[WORD_W-1:1]};
    end else if (ctl.writeByte) begin
      for (int k = 0; k < NUM_BYTES; k++) begin
        if (byteHit[k])
          stageNext[WORD_W-1-k*DATA_W -: DATA_W] = dataIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageReg  <= '0;
      activeReg <= '0;
    end else begin
      stageReg <= stageNext;
      if (ctl.commit)
        activeReg <= stageReg;
    end
  end

  assign freqWord  = activeReg[FREQ_W-1:0];
  assign phaseWord = activeReg[WORD_W-1 -: PHASE_W];
  assign powerDown = activeReg[WORD_W-1-PHASE_W];

endmodule

// File: rtl/dds_prog_loader.sv
module dds_prog_loader
  import dds_loader_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 5,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serialMode,
  input  logic               wordStrobe,
  input  logic               commitStrobe,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [FREQ_W-1:0]  freqWord,
  output logic [PHASE_W-1:0] phaseWord,
  output logic               powerDown
);

  localparam int NUM_BYTES = (FREQ_W + DATA_W) / DATA_W;
  localparam int PTR_W     = $clog2(NUM_BYTES + 1);

  loadCtl_t         ctl;
  logic [PTR_W-1:0] bytePtr;

  dds_loader_ctrl #(
    .NUM_BYTES(NUM_BYTES),
    .PTR_W    (PTR_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .serialMode  (serialMode),
    .wordStrobe  (wordStrobe),
    .commitStrobe(commitStrobe),
    .ctl         (ctl),
    .bytePtr     (bytePtr)
  );

  dds_loader_path #(
    .FREQ_W   (FREQ_W),
    .PHASE_W  (PHASE_W),
    .DATA_W   (DATA_W),
    .NUM_BYTES(NUM_BYTES),
    .PTR_W    (PTR_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .bytePtr  (bytePtr),
    .dataIn   (dataIn),
    .freqWord (freqWord),
    .phaseWord(phaseWord),
    .powerDown(powerDown)
  );

endmodule

// File: rtl/dds_loader_chk.sv
module dds_loader_chk #(
  parameter int FREQ_W    = 32,
  parameter int PHASE_W   = 5,
  parameter int NUM_BYTES = 5,
  parameter int PTR_W     = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               serialMode,
  input logic               commitStrobe,
  input logic [FREQ_W-1:0]  freqWord,
  input logic [PHASE_W-1:0] phaseWord,
  input logic               powerDown,
  input logic [PTR_W-1:0]   bytePtr
);

  // R5
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bytePtr <= PTR_W'(NUM_BYTES));

  // R5
  ptr_full_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bytePtr == PTR_W'(NUM_BYTES) && !$rose(commitStrobe)) |=> bytePtr == PTR_W'(NUM_BYTES));

  // R6
  commit_rewinds_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(commitStrobe) |=> bytePtr == '0);

  // R6
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(commitStrobe) |=> ($stable(freqWord) && $stable(phaseWord) && $stable(powerDown)));

  // R7
  serial_ptr_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serialMode && !$rose(commitStrobe)) |=> $stable(bytePtr));

endmodule

bind dds_prog_loader dds_loader_chk #(
  .FREQ_W   (FREQ_W),
  .PHASE_W  (PHASE_W),
  .NUM_BYTES(NUM_BYTES),
  .PTR_W    (PTR_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .serialMode  (serialMode),
  .commitStrobe(commitStrobe),
  .freqWord    (freqWord),
  .phaseWord   (phaseWord),
  .powerDown   (powerDown),
  .bytePtr     (bytePtr)
);

// File: tb/sim_dds_prog_loader.sv
module sim_dds_prog_loader;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serialMode = 1'b0;
  logic        wordStrobe = 1'b0;
  logic        commitStrobe = 1'b0;
  logic [7:0]  dataIn = '0;
  logic [31:0] freqWord;
  logic [4:0]  phaseWord;
  logic        powerDown;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_prog_loader u0 (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .wordStrobe(wordStrobe),
    .commitStrobe(commitStrobe), .dataIn(dataIn), .freqWord(freqWord),
    .phaseWord(phaseWord), .powerDown(powerDown)
  );

  task automatic check(input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk);
    dataIn = d;
    wordStrobe = 1'b1;
    @(negedge clk);
    wordStrobe = 1'b0;
  endtask

  task automatic doCommit();
    @(negedge clk);
    commitStrobe = 1'b1;
    @(negedge clk);
    commitStrobe = 1'b0;
  endtask

  task automatic loadFrame(input logic [7:0] b0, input logic [31:0] f);
    writeByte(b0);
    writeByte(f[31:24]);
    writeByte(f[23:16]);
    writeByte(f[15:8]);
    writeByte(f[7:0]);
  endtask

  task automatic sendSerial(input logic [39:0] frame);
    for (int i = 0; i < 40; i++) begin
      logic b;
      b = frame[i];
      writeByte({b, {7{~b}}});
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "freq after reset", 40'(freqWord), 40'h0);
    check("R1", "phase after reset", 40'(phaseWord), 40'h0);
    check("R1", "pd after reset", 40'(powerDown), 40'h0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testParallel();
    // settings byte: phase 0x15, pd 1, reserved 0
    loadFrame(8'hAC, 32'h12345678);
    check("R6", "freq before commit", 40'(freqWord), 40'h0);
    doCommit();
    check("R3", "freq msb first", 40'(freqWord), 40'h12345678);
    check("R2", "phase field", 40'(phaseWord), 40'h15);
    check("R2", "pd field", 40'(powerDown), 40'h1);
  endtask

  task automatic testOverrun();
    loadFrame(8'h08, 32'hA1B2C3D4);
    writeByte(8'hFF);
    writeByte(8'hFF);
    doCommit();
    check("R5", "freq after extra writes", 40'(freqWord), 40'hA1B2C3D4);
    check("R5", "phase after extra writes", 40'(phaseWord), 40'h01);
    // partial frame: only first two slots rewritten
    writeByte(8'hF0);
    writeByte(8'h5A);
    doCommit();
    check("R4", "partial freq", 40'(freqWord), 40'h5AB2C3D4);
    check("R4", "partial phase", 40'(phaseWord), 40'h1E);
    check("R4", "partial pd", 40'(powerDown), 40'h0);
  endtask

  task automatic testReserved();
    // phase 3, pd 0, reserved bits 2'b11
    loadFrame(8'h1B, 32'hCAFEF00D);
    doCommit();
    check("R9", "phase with reserved set", 40'(phaseWord), 40'h03);
    check("R9", "pd with reserved set", 40'(powerDown), 40'h0);
    check("R9", "freq with reserved set", 40'(freqWord), 40'hCAFEF00D);
    loadFrame(8'h00, 32'h01020304);
    doCommit();
    check("R9", "still parallel afterwards", 40'(freqWord), 40'h01020304);
  endtask

  task automatic testCollision();
    writeByte(8'h50);
    @(negedge clk);
    dataIn = 8'h77;
    wordStrobe = 1'b1;
    commitStrobe = 1'b1;
    @(negedge clk);
    wordStrobe = 1'b0;
    commitStrobe = 1'b0;
    check("R10", "phase on collision", 40'(phaseWord), 40'h0A);
    check("R10", "freq on collision", 40'(freqWord), 40'h01020304);
    writeByte(8'hF8);
    doCommit();
    check("R10", "dropped write left freq", 40'(freqWord), 40'h01020304);
    check("R10", "next write hit first slot", 40'(phaseWord), 40'h1F);
  endtask

  task automatic testSerial();
    serialMode = 1'b1;
    // phase 0x09, pd 1, reserved 0, freq DEADBEEF
    sendSerial({5'h09, 1'b1, 2'b00, 32'hDEADBEEF});
    check("R7", "freq before commit", 40'(freqWord), 40'h01020304);
    doCommit();
    check("R7", "serial freq", 40'(freqWord), 40'hDEADBEEF);
    check("R7", "serial phase", 40'(phaseWord), 40'h09);
    check("R7", "serial pd", 40'(powerDown), 40'h1);
  endtask

  task automatic testLongSerial();
    for (int i = 0; i < 5; i++) writeByte(8'h80);
    sendSerial({5'h12, 1'b0, 2'b00, 32'h0F1E2D3C});
    doCommit();
    check("R8", "overlong freq", 40'(freqWord), 40'h0F1E2D3C);
    check("R8", "overlong phase", 40'(phaseWord), 40'h12);
    check("R8", "overlong pd", 40'(powerDown), 40'h0);
    serialMode = 1'b0;
  endtask

  initial begin
    testReset();
    testParallel();
    testOverrun();
    testReserved();
    testCollision();
    testSerial();
    testLongSerial();
    testReset();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule